// File: doc/BRIEF.md
# Two-Wire Byte-Write Memory Slave (16 x 8)

This block is the slave side of a two-wire serial memory that holds sixteen bytes in a register array. The SCL and SDA lines are sampled with the fast system clock. The block finds bus Start and Stop conditions and decodes the control byte that follows each Start. It takes a word address, buffers write data, and commits a single byte through a timed programming cycle. SDA is open-drain. The block never drives the line high; it only raises a pull-low enable, and the pad pulls the line to ground.

A write consists of a control byte, an address byte and one or more data bytes. The programming cycle begins only when the Stop arrives at a byte boundary. The array is updated when the cycle ends, and `busy_o` is high for the whole cycle. Reads return the byte at the address pointer, most significant bit first. A read can start from the current pointer, or from a new pointer that an address byte loads before a repeated Start.

Top module: `i2c_nvm16_slave`

## Requirements
- R1: In the control byte, bits 7..4 must equal 4'b1010 for the slave to respond. Bits 3..1 have no effect. Bit 0 selects the operation: 1 means read and 0 means write. When the code does not match, the slave leaves SDA released for the whole transfer.
- R2: Each accepted control, address or write-data byte is acknowledged. The slave holds SDA low through the whole ninth SCL high phase of that byte.
- R3: In a write, the low four bits of the second byte load the address pointer. Bits 7..4 of that byte are ignored.
- R4: A Stop that follows a complete data byte starts the programming cycle. Such a Stop may arrive after at most the single SCL pulse that precedes it. `busy_o` then stays high for exactly PROG_CYCLES clocks, and the addressed location holds the byte when the cycle ends.
- R5: While `busy_o` is high, no byte is acknowledged, including a control byte with a matching code.
- R6: A Stop that arrives before one full data byte has been received aborts the write. In this case `busy_o` stays low and the memory is unchanged.
- R7: When several data bytes are sent, each new complete byte replaces the buffered one. Only the last complete byte is programmed.
- R8: A Stop that arrives after two to seven bits of a further byte aborts the entire write, and nothing is programmed.
- R9: While `supply_low_i` is high, no programming cycle starts. If `supply_low_i` is high in the last cycle of a programming cycle, the array is not written.
- R10: A write leaves the pointer on the location just written. A following read that starts from the current pointer returns the written byte.
- R11: A read shifts out the byte at the pointer, most significant bit first. After each byte the pointer increments modulo 16. A master acknowledge continues the read with the next byte. A missing acknowledge makes the slave release SDA and wait for Start.
- R12: A control write, an address byte, a repeated Start and a control read together return the byte at the new address.
- R13: `sda_pull_o` changes only while SCL is low.
- R14: After reset, `sda_pull_o` and `busy_o` are low and every location reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| supply_low_i | input | 1 | High when supply is too low to program |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| busy_o | output | 1 | High during the internal programming cycle |

## Verification
Some properties are checked on every clock. SDA stays released while a programming cycle runs. The pull enable only moves while SCL is low. A programming cycle starts only on the clock after a detected Stop, never while the supply is low, and never lasts longer than PROG_CYCLES. Other behaviour shows only as stored contents and acknowledge patterns, so only the bench scenarios can reveal it. This covers don't-care address bits, aborts on early or mid-byte Stops, last-byte-wins buffering, pointer hold after a write, pointer wrap on sequential reads, and an inhibit that arrives at the end of a programming cycle.

// File: rtl/nvm16_pkg.sv
package nvm16_pkg;

    localparam int NVM_AW = 4;
    localparam int NVM_DW = 8;
    localparam int CNT_W  = $clog2(NVM_DW + 1);
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_ADDR,
        PH_WDATA,
        PH_ACK,
        PH_RDATA,
        PH_MACK
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        phase_e              after;
        logic [CNT_W-1:0]    cnt;
        logic [NVM_DW-1:0]   sh;
        logic [NVM_DW-1:0]   tx;
        logic [NVM_AW-1:0]   ptr;
        logic [NVM_DW-1:0]   wbuf;
        logic                have;
        logic                pull;
        logic                mack;
    } ctl_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } smp_t;

    smp_t q, d;
    logic scl_s;

    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_o = q.sda_sh[STAGES-1];

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    // Edge and condition decode on the synchronized lines
    assign scl_rise_o = scl_s & ~q.scl_p;
    assign scl_fall_o = ~scl_s & q.scl_p;
    assign start_o    = scl_s & q.scl_p & q.sda_p & ~sda_o;
    assign stop_o     = scl_s & q.scl_p & ~q.sda_p & sda_o;

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int              DEPTH       = 16,
    parameter int              DW          = 8,
    parameter int              PROG_CYCLES = 16,
    parameter logic [DW-1:0]   ERASED      = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_i,
    input  logic [$clog2(DEPTH)-1:0] commit_addr_i,
    input  logic [DW-1:0]            commit_data_i,
    input  logic                     supply_low_i,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
    output logic [DW-1:0]            rd_data_o,
    output logic                     busy_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic                     busy;
        logic [CW-1:0]            cnt;
        logic [AW-1:0]            addr;
        logic [DW-1:0]            data;
    } arr_t;

    arr_t q, d;

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                if (!supply_low_i) d.mem[q.addr] = q.data;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (commit_i && !supply_low_i) begin
            d.busy = 1'b1;
            d.cnt  = CW'(PROG_CYCLES - 1);
            d.addr = commit_addr_i;
            d.data = commit_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mem  <= {DEPTH{ERASED}};
            q.busy <= 1'b0;
            q.cnt  <= '0;
            q.addr <= '0;
            q.data <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data_o = q.mem[rd_addr_i];
    assign busy_o    = q.busy;

endmodule

// File: rtl/i2c_nvm16_slave.sv
module i2c_nvm16_slave
    import nvm16_pkg::*;
#(
    parameter int PROG_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic supply_low_i,
    output logic sda_pull_o,
    output logic busy_o
);

    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic commit;
    logic [NVM_DW-1:0] rd_data;
    ctl_t q, d;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    nvm_cell_array #(
        .DEPTH       (2 ** NVM_AW),
        .DW          (NVM_DW),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_arr (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit),
        .commit_addr_i (q.ptr),
        .commit_data_i (q.wbuf),
        .supply_low_i  (supply_low_i),
        .rd_addr_i     (q.ptr),
        .rd_data_o     (rd_data),
        .busy_o        (busy_o)
    );

    always_comb begin
        d      = q;
        commit = 1'b0;
        if (start_ev) begin
            d.ph   = PH_CTRL;
            d.cnt  = '0;
            d.pull = 1'b0;
            d.have = 1'b0;
        end else if (stop_ev) begin
            // at most the one SCL pulse that carries the Stop itself
            commit = (q.ph == PH_WDATA) && q.have && (q.cnt <= CNT_W'(1));
            d.ph   = PH_IDLE;
            d.cnt  = '0;
            d.pull = 1'b0;
            d.have = 1'b0;
        end else begin
            unique case (q.ph)
                PH_CTRL, PH_ADDR, PH_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[NVM_DW-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNT_W'(NVM_DW)) begin
                        d.cnt  = '0;
                        d.pull = 1'b1;
                        d.ph   = PH_ACK;
                        if (q.ph == PH_CTRL) begin
                            if (q.sh[NVM_DW-1 -: 4] == DEV_CODE && !busy_o) begin
                                d.after = q.sh[0] ? PH_RDATA : PH_ADDR;
                            end else begin
                                d.pull = 1'b0;
                                d.ph   = PH_IDLE;
                            end
                        end else if (q.ph == PH_ADDR) begin
                            d.ptr   = q.sh[NVM_AW-1:0];
                            d.after = PH_WDATA;
                        end else begin
                            d.wbuf  = q.sh;
                            d.have  = 1'b1;
                            d.after = PH_WDATA;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.ph   = q.after;
                        d.pull = 1'b0;
                        if (q.after == PH_RDATA) begin
                            d.tx   = rd_data;
                            d.pull = ~rd_data[NVM_DW-1];
                        end
                    end
                end
                PH_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == CNT_W'(NVM_DW)) begin
                            d.cnt  = '0;
                            d.pull = 1'b0;
                            d.ptr  = q.ptr + 1'b1;
                            d.ph   = PH_MACK;
                        end else begin
                            d.tx   = {q.tx[NVM_DW-2:0], 1'b0};
                            d.pull = ~q.tx[NVM_DW-2];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.ph   = PH_RDATA;
                            d.tx   = rd_data;
                            d.pull = ~rd_data[NVM_DW-1];
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pull_o = q.pull;

endmodule

// File: rtl/nvm16_checker.sv
module nvm16_checker #(
    parameter int PROG_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic supply_low_i,
    input logic sda_pull_o,
    input logic busy_o,
    input logic stop_ev
);

    int unsigned run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run <= 0;
        else if (busy_o) run <= run + 1;
        else             run <= 0;
    end

    p_quiet_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_pull_o);

    p_pull_moves_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_ev));

    p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> run < PROG_CYCLES);

    p_no_start_low_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && supply_low_i) |=> !busy_o);

endmodule

bind i2c_nvm16_slave nvm16_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .supply_low_i (supply_low_i),
    .sda_pull_o   (sda_pull_o),
    .busy_o       (busy_o),
    .stop_ev      (stop_ev)
);

// File: tb/sim_i2c_nvm16_slave.sv
`timescale 1ns/1ps
module sim_i2c_nvm16_slave;

    localparam int PROG = 1500;
    localparam int H    = 20;

    // {control byte, address byte, data byte}
    localparam logic [23:0] VEC [6] = '{
        24'hA0_00_5A,
        24'hAE_F1_C3,
        24'hA4_32_00,
        24'hAA_93_FF,
        24'hA2_C4_81,
        24'hA8_5F_3C
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic supply_low = 1'b0;
    logic pull, busy;
    logic line;

    assign line = sda_m & ~pull;

    always #2 clk = ~clk;

    i2c_nvm16_slave #(.PROG_CYCLES(PROG)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (line),
        .supply_low_i (supply_low),
        .sda_pull_o   (pull),
        .busy_o       (busy)
    );

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;
    int r13_viol = 0;
    bit done = 1'b0;
    logic pull_prev = 1'b0;
    logic [7:0] exp_mem [16];

    always @(negedge clk) begin
        if (busy === 1'b1) busy_cnt++;
        if (rst_n && pull !== pull_prev && scl === 1'b1) r13_viol++;
        pull_prev = pull;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wt(H);
        scl = 1'b1;   wt(H);
        sda_m = 1'b0; wt(H);
        scl = 1'b0;   wt(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wt(H);
        scl = 1'b1;   wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wt(H);
            scl = 1'b1;     wt(H);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(H);
        scl = 1'b1;   wt(H/2);
        ack = !line;  wt(H/2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wt(H);
            scl = 1'b1; wt(H/2);
            b = {b[6:0], line}; wt(H/2);
            scl = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wt(H);
        scl = 1'b1; wt(H);
        scl = 1'b0;
    endtask

    task automatic write_cycle(input logic [7:0] c, input logic [7:0] a, input logic [7:0] v, output bit ok);
        bit a1, a2, a3;
        bus_start;
        send_byte(c, a1);
        send_byte(a, a2);
        send_byte(v, a3);
        bus_stop;
        ok = a1 & a2 & a3;
    endtask

    task automatic rand_read(input logic [7:0] c, input logic [7:0] a, output logic [7:0] v, output bit ok);
        bit a1, a2, a3;
        bus_start;
        send_byte(c & 8'hFE, a1);
        send_byte(a, a2);
        bus_start;
        send_byte(c | 8'h01, a3);
        recv_byte(1'b0, v);
        bus_stop;
        ok = a1 & a2 & a3;
    endtask

    task automatic wait_idle;
        while (busy === 1'b1) wt(1);
        wt(4);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            summary;
            $finish;
        end
    end

    initial begin
        bit ok, ak;
        logic [7:0] rd, b0, b1, b2;
        logic [7:0] ad;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'hFF;

        wt(5);
        check(pull === 1'b0, "R14 pull in reset", 32'(pull), 0);
        check(busy === 1'b0, "R14 busy in reset", 32'(busy), 0);
        rst_n = 1'b1;
        wt(10);

        // R14: erased contents after reset; R12 random read path
        rand_read(8'hA0, 8'h00, rd, ok);
        check(ok, "R2 acks on reset read", 32'(ok), 1);
        check(rd === 8'hFF, "R14 erased location", 32'(rd), 32'hFF);

        // R1: foreign device codes are not acknowledged
        bus_start; send_byte(8'h90, ak); bus_stop;
        check(!ak, "R1 code 1001 ignored", 32'(ak), 0);
        bus_start; send_byte(8'hB1, ak); bus_stop;
        check(!ak, "R1 code 1011 ignored", 32'(ak), 0);

        // Vector table: write, measure programming time, read back
        for (int i = 0; i < 6; i++) begin
            busy_cnt = 0;
            write_cycle(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], ok);
            check(ok, "R1 R2 write acks", 32'(ok), 1);
            wait_idle;
            check(busy_cnt == PROG, "R4 programming length", 32'(busy_cnt), 32'(PROG));
            exp_mem[VEC[i][11:8]] = VEC[i][7:0];
            ad = {~VEC[i][15:12], VEC[i][11:8]};
            rand_read(VEC[i][23:16], ad, rd, ok);
            check(ok, "R12 read acks", 32'(ok), 1);
            check(rd === exp_mem[VEC[i][11:8]], "R3 R12 readback", 32'(rd), 32'(exp_mem[VEC[i][11:8]]));
        end

        // R5: no acknowledge while programming
        write_cycle(8'hA0, 8'h0A, 8'h77, ok);
        bus_start; send_byte(8'hA0, ak); bus_stop;
        check(busy === 1'b1, "R5 still busy", 32'(busy), 1);
        check(!ak, "R5 no ack while busy", 32'(ak), 0);
        wait_idle;
        exp_mem[10] = 8'h77;

        // R10: current-address read returns just-written byte
        bus_start; send_byte(8'hA1, ak); recv_byte(1'b0, rd); bus_stop;
        check(rd === 8'h77, "R10 pointer holds", 32'(rd), 32'h77);

        // R6: Stop after the address byte aborts
        bus_start; send_byte(8'hA0, ak); send_byte(8'h0B, ak); bus_stop;
        wt(50);
        check(busy === 1'b0, "R6 no programming", 32'(busy), 0);
        bus_start; send_byte(8'hA0, ak); bus_stop;
        wt(50);
        check(busy === 1'b0, "R6 stop after control only", 32'(busy), 0);
        rand_read(8'hA0, 8'h0B, rd, ok);
        check(rd === 8'hFF, "R6 memory unchanged", 32'(rd), 32'hFF);

        // R7: last complete byte wins
        bus_start; send_byte(8'hA0, ak); send_byte(8'h0C, ak);
        send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak);
        bus_stop;
        wait_idle;
        rand_read(8'hA0, 8'h0C, rd, ok);
        check(rd === 8'h33, "R7 last byte programmed", 32'(rd), 32'h33);

        // R8: partial byte after a complete one aborts
        bus_start; send_byte(8'hA0, ak); send_byte(8'h0D, ak); send_byte(8'h44, ak);
        send_bits(8'h55, 4);
        bus_stop;
        wt(50);
        check(busy === 1'b0, "R8 no programming", 32'(busy), 0);
        rand_read(8'hA0, 8'h0D, rd, ok);
        check(rd === 8'hFF, "R8 memory unchanged", 32'(rd), 32'hFF);

        // R9: supply low at Stop
        supply_low = 1'b1;
        write_cycle(8'hA0, 8'h0E, 8'h66, ok);
        wt(50);
        check(busy === 1'b0, "R9 inhibited start", 32'(busy), 0);
        supply_low = 1'b0;
        // R9: supply low at the end of the cycle
        write_cycle(8'hA0, 8'h0E, 8'h66, ok);
        check(busy === 1'b1, "R9 cycle started", 32'(busy), 1);
        supply_low = 1'b1;
        wait_idle;
        supply_low = 1'b0;
        rand_read(8'hA0, 8'h0E, rd, ok);
        check(rd === 8'hFF, "R9 memory unchanged", 32'(rd), 32'hFF);

        // R11: sequential read with wrap from 15 to 0
        write_cycle(8'hA0, 8'h0F, 8'hA5, ok);
        wait_idle;
        exp_mem[15] = 8'hA5;
        bus_start; send_byte(8'hA0, ak); send_byte(8'h0F, ak);
        bus_start; send_byte(8'hA1, ak);
        recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b0, b2);
        wt(H);
        check(pull === 1'b0, "R11 released after nack", 32'(pull), 0);
        bus_stop;
        check(b0 === exp_mem[15], "R11 first byte", 32'(b0), 32'(exp_mem[15]));
        check(b1 === exp_mem[0], "R11 wrap to 0", 32'(b1), 32'(exp_mem[0]));
        check(b2 === exp_mem[1], "R11 next byte", 32'(b2), 32'(exp_mem[1]));
        bus_start; send_byte(8'hA1, ak); recv_byte(1'b0, rd); bus_stop;
        check(rd === exp_mem[2], "R11 pointer advanced", 32'(rd), 32'(exp_mem[2]));

        check(r13_viol == 0, "R13 pull changed with SCL high", 32'(r13_viol), 0);

        done = 1'b1;
        summary;
        $finish;
    end

endmodule